// File: doc/BRIEF.md
# Digit Result Parity Predictor and Carry Checker

This block runs beside a decimal digit adder and guards each digit it produces. On every strobed digit it receives the two operand digits with their odd-parity bits, the nines-complement enables for each operand, the carry into the digit, and the decimal-correct and sign-control indications. It also receives what the main adder produced: its complemented A digit, its result digit and its carry out. It does not add the result bits together to get a parity bit. Instead it runs a shadow binary adder, which has no output latch, no decimal correction and no sign control. The shadow adder records which bits of the complemented B digit the add flips. The parity of that change vector is combined with three other known parity changes: the one from complementing B, the one from the +6 decimal correction and the one from the sign flip. The result is a predicted parity bit for the result digit.

The predicted bit is registered as `parOut`. In the same cycle the main result digit is checked against it for odd parity. The complemented A digit from the main path gets a separate check against its own predicted parity. A shadow carry register follows the shadow adder's carry out. It checks the main adder's carry out on every digit, and on later digits it also checks the carry that enters the next digit. Parity faults and carry faults set two separate sticky flags. Only a clear pulse resets them.

Top module: `alu_parity_predictor`

## Requirements
- R1: After reset, with no digit strobed yet, `parOut`, `parityErr` and `carryErr` are all 0.
- R2: On a strobed digit, the block forms the complemented operands Ac and Bc. Each is the operand itself, or 9 minus the operand when its complement enable is 1. The expected result is ((Ac + Bc + carryIn) mod 16, plus 6 mod 16 when `decCorrect` is 1), with bit 3 inverted when `signCtl` is 1. Provided `bPar` makes {bDigit,bPar} odd, the bit `parOut` that follows the clock edge makes {expected result, parOut} odd.
- R3: If a strobed `resDigit` together with the predicted parity bit has even parity, `parityErr` is 1 after that clock edge.
- R4: If `bPar` gives {bDigit,bPar} even parity, the predicted `parOut` is inverted and `parityErr` is set.
- R5: If the parity of `aCmpDigit` differs from the parity of the correctly complemented A digit, `parityErr` is set. The check uses `aPar` as the parity reference for A.
- R6: The expected carry out of a digit is the binary carry out of Ac + Bc + carryIn, ORed with `decCorrect`. A strobed `carryOut` that differs from it sets `carryErr`.
- R7: After at least one digit has been strobed, a digit strobed with `firstDigit` = 0 must carry in the expected carry out of the previous digit. If it does not, `carryErr` is set. When `firstDigit` is 1 the carry in is not checked.
- R8: Both error flags are sticky. A `clearFlags` pulse resets them at the next edge. If a new error arrives in the same cycle as the clear, the flag is 1 after that edge.
- R9: A cycle with `digitValid` = 0 leaves `parOut` unchanged. In such a cycle the error flags change only through a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| digitValid | input | 1 | Strobe: a digit and its adder results are present |
| firstDigit | input | 1 | Marks the lowest digit of an operation (carry in unchecked) |
| clearFlags | input | 1 | Clears the sticky error flags |
| aDigit | input | 4 | A operand digit |
| aPar | input | 1 | Odd-parity bit of aDigit |
| aCompEn | input | 1 | A is nines complemented |
| aCmpDigit | input | 4 | Complemented A digit from the main path |
| bDigit | input | 4 | B operand digit |
| bPar | input | 1 | Odd-parity bit of bDigit |
| bCompEn | input | 1 | B is nines complemented |
| carryIn | input | 1 | Carry into this digit |
| decCorrect | input | 1 | Decimal correction (+6) applied to this digit |
| signCtl | input | 1 | Sign control flips bit 3 of the result |
| resDigit | input | 4 | Result digit from the main adder |
| carryOut | input | 1 | Carry out of the main adder for this digit |
| parOut | output | 1 | Predicted parity bit for the last strobed result digit |
| parityErr | output | 1 | Sticky parity error (result or A complement) |
| carryErr | output | 1 | Sticky carry error |

## Verification
Two cases can land in one cycle, and the bench drives both. In the first, a clear pulse arrives together with a digit that carries a fault in the A complement path, and the parity flag is expected to stay set, not to be cleared. In the second, a digit is strobed with a wrong carry in while it is not the first digit. For that case the shadow carry register holds the previous digit's expected carry, and the digit's own carry out is checked in the same cycle. The bench has to set `carryErr` from the carry-in mismatch alone. A scoreboard model with its own sticky flags and its own previous-carry tracking judges both cases one edge after the strobe.

// File: rtl/alu_parity_pkg.sv
package alu_parity_pkg;
  localparam int DIGIT_W = 4;
  localparam int NINE = 9;
  localparam int DEC_ADJ = 6;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef struct packed {
    logic capture;
    logic checkTemp;
    logic clear;
  } strobes_t;

  function automatic digit_t ninesOf(input digit_t d);
    return digit_t'(NINE) - d;
  endfunction
endpackage

// File: rtl/alu_parity_ctrl.sv
module alu_parity_ctrl
  import alu_parity_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     digitValid,
  input  logic     firstDigit,
  input  logic     clearFlags,
  output strobes_t st
);
  logic tempArmed;

  always_ff @(posedge clk) begin
    if (!rstN) tempArmed <= 1'b0;
    else if (digitValid) tempArmed <= 1'b1;
  end

  always_comb begin
    st.capture   = digitValid;
    st.checkTemp = digitValid && !firstDigit && tempArmed;
    st.clear     = clearFlags;
  end
endmodule

// File: rtl/alu_parity_dp.sv
module alu_parity_dp
  import alu_parity_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t st,
  input  digit_t   aDigit,
  input  logic     aPar,
  input  logic     aCompEn,
  input  digit_t   aCmpDigit,
  input  digit_t   bDigit,
  input  logic     bPar,
  input  logic     bCompEn,
  input  logic     carryIn,
  input  logic     decCorrect,
  input  logic     signCtl,
  input  digit_t   resDigit,
  input  logic     carryOut,
  output logic     parOut,
  output logic     parityErr,
  output logic     carryErr
);
  digit_t aC, bC, sumRaw, sumCorr;
  logic [DIGIT_W:0] sumWide;
  logic chkCarry, shadowCarry, tempCarryQ;
  logic bChange, addChange, decChange, predData, parGen;
  logic aPredData, resBad, aBad, parityBad, carryBad;

  // shadow adder: binary add only, no latch, no correction, no sign
  always_comb begin
    aC       = aCompEn ? ninesOf(aDigit) : aDigit;
    bC       = bCompEn ? ninesOf(bDigit) : bDigit;
    sumWide  = {1'b0, aC} + {1'b0, bC} + {{DIGIT_W{1'b0}}, carryIn};
    sumRaw   = sumWide[DIGIT_W-1:0];
    chkCarry = sumWide[DIGIT_W];
    sumCorr  = decCorrect ? sumRaw + digit_t'(DEC_ADJ) : sumRaw;
  end

  // parity change of each stage that modifies the B digit
  always_comb begin
    bChange   = ^(bDigit ^ bC);
    addChange = ^(sumRaw ^ bC);
    decChange = ^(sumRaw ^ sumCorr);
    predData  = ~bPar ^ bChange ^ addChange ^ decChange ^ signCtl;
    parGen    = ~predData;
    resBad    = ~(^{resDigit, parGen});
    aPredData = ~aPar ^ (^(aDigit ^ aC));
    aBad      = (^aCmpDigit) != aPredData;
    parityBad = resBad || aBad;
  end

  always_comb begin
    shadowCarry = chkCarry | decCorrect;
    carryBad    = (carryOut != shadowCarry) ||
                  (st.checkTemp && (carryIn != tempCarryQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parOut     <= 1'b0;
      tempCarryQ <= 1'b0;
      parityErr  <= 1'b0;
      carryErr   <= 1'b0;
    end else begin
      if (st.capture) begin
        parOut     <= parGen;
        tempCarryQ <= shadowCarry;
      end
      parityErr <= (parityErr && !st.clear) || (st.capture && parityBad);
      carryErr  <= (carryErr && !st.clear) || (st.capture && carryBad);
    end
  end
endmodule

// File: rtl/alu_parity_predictor.sv
module alu_parity_predictor
  import alu_parity_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       digitValid,
  input  logic       firstDigit,
  input  logic       clearFlags,
  input  logic [3:0] aDigit,
  input  logic       aPar,
  input  logic       aCompEn,
  input  logic [3:0] aCmpDigit,
  input  logic [3:0] bDigit,
  input  logic       bPar,
  input  logic       bCompEn,
  input  logic       carryIn,
  input  logic       decCorrect,
  input  logic       signCtl,
  input  logic [3:0] resDigit,
  input  logic       carryOut,
  output logic       parOut,
  output logic       parityErr,
  output logic       carryErr
);
  strobes_t st;

  alu_parity_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .digitValid(digitValid),
    .firstDigit(firstDigit), .clearFlags(clearFlags), .st(st)
  );

  alu_parity_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .aDigit(aDigit), .aPar(aPar), .aCompEn(aCompEn), .aCmpDigit(aCmpDigit),
    .bDigit(bDigit), .bPar(bPar), .bCompEn(bCompEn), .carryIn(carryIn),
    .decCorrect(decCorrect), .signCtl(signCtl), .resDigit(resDigit),
    .carryOut(carryOut), .parOut(parOut), .parityErr(parityErr),
    .carryErr(carryErr)
  );
endmodule

// File: rtl/alu_parity_chk.sv
module alu_parity_chk (
  input logic       clk,
  input logic       rstN,
  input logic       digitValid,
  input logic       clearFlags,
  input logic [3:0] resDigit,
  input logic       parOut,
  input logic       parityErr,
  input logic       carryErr
);
  // R2/R3: after a strobe, result plus parity bit is odd unless the flag is up
  a_r2_odd_result: assert property (@(posedge clk) disable iff (!rstN)
    digitValid |=> ((^{$past(resDigit), parOut}) == 1'b1) || parityErr);

  // R8: flags hold without a clear
  a_r8_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !clearFlags) |=> parityErr);
  a_r8_carry_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (carryErr && !clearFlags) |=> carryErr);

  // R8: clear without a strobe drops both flags
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clearFlags && !digitValid) |=> (!parityErr && !carryErr));

  // R9: idle cycles keep the parity bit and raise no flag
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !digitValid |=> $stable(parOut));
  a_r9_no_rise_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(parityErr) || $rose(carryErr)) |-> $past(digitValid));
endmodule

bind alu_parity_predictor alu_parity_chk u_chk (
  .clk(clk), .rstN(rstN), .digitValid(digitValid), .clearFlags(clearFlags),
  .resDigit(resDigit), .parOut(parOut), .parityErr(parityErr),
  .carryErr(carryErr)
);

// File: tb/tb_alu_parity_predictor.sv
module tb_alu_parity_predictor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic digitValid = 0, firstDigit = 0, clearFlags = 0;
  logic [3:0] aDigit = 0, aCmpDigit = 0, bDigit = 0, resDigit = 0;
  logic aPar = 1, aCompEn = 0, bPar = 1, bCompEn = 0, carryIn = 0;
  logic decCorrect = 0, signCtl = 0, carryOut = 0;
  logic parOut, parityErr, carryErr;

  always #5 clk = ~clk;

  alu_parity_predictor dut (.*);

  typedef struct {
    logic  par;
    logic  perr;
    logic  cerr;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic expPar = 0, expPerr = 0, expCerr = 0, prevCarry = 0, armed = 0;
  bit done = 0;

  task automatic check1(input logic act, input logic exp, input string what, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // fault: 0 none, 1 result bit 0 flipped, 2 bPar flipped, 3 A complement bit 1 flipped,
  //        4 carryOut flipped
  task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic ac,
                       input logic bc, input logic cin, input logic dec, input logic sgn,
                       input logic first, input logic clr, input int fault, input string req);
    logic [3:0] aC, bC, res;
    logic [4:0] s;
    logic carry, pEv, cEv;
    exp_t e;
    aC = ac ? 4'd9 - a : a;
    bC = bc ? 4'd9 - b : b;
    s = {1'b0, aC} + {1'b0, bC} + {4'd0, cin};
    res = s[3:0] + (dec ? 4'd6 : 4'd0);
    if (sgn) res = res ^ 4'b1000;
    carry = s[4] | dec;
    @(negedge clk);
    digitValid = 1; firstDigit = first; clearFlags = clr;
    aDigit = a; aPar = ~^a; aCompEn = ac; aCmpDigit = aC ^ ((fault == 3) ? 4'd2 : 4'd0);
    bDigit = b; bPar = (~^b) ^ (fault == 2); bCompEn = bc;
    carryIn = cin; decCorrect = dec; signCtl = sgn;
    resDigit = res ^ ((fault == 1) ? 4'd1 : 4'd0);
    carryOut = carry ^ (fault == 4);
    pEv = (fault == 1) || (fault == 2) || (fault == 3);
    cEv = (fault == 4) || (!first && armed && (cin != prevCarry));
    expPar = (~^res) ^ (fault == 2);
    expPerr = (expPerr && !clr) || pEv;
    expCerr = (expCerr && !clr) || cEv;
    prevCarry = carry;
    armed = 1;
    e.par = expPar; e.perr = expPerr; e.cerr = expCerr; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input logic clr, input string req);
    exp_t e;
    @(negedge clk);
    digitValid = 0; clearFlags = clr;
    resDigit = ~resDigit; carryOut = ~carryOut;
    expPerr = expPerr && !clr;
    expCerr = expCerr && !clr;
    e.par = expPar; e.perr = expPerr; e.cerr = expCerr; e.req = req;
    q.push_back(e);
  endtask

  // monitor: registered outputs settle after the edge following the strobe
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check1(parOut, e.par, "parOut", e.req);
        check1(parityErr, e.perr, "parityErr", e.req);
        check1(carryErr, e.cerr, "carryErr", e.req);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check1(parOut, 1'b0, "parOut", "R1");
    check1(parityErr, 1'b0, "parityErr", "R1");
    check1(carryErr, 1'b0, "carryErr", "R1");
    @(negedge clk); rstN = 1;
    // R2: plain add, decimal corrected add, carry chain, complement with sign
    drive(4'd3, 4'd4, 0, 0, 0, 0, 0, 1, 0, 0, "R2");
    drive(4'd5, 4'd7, 0, 0, 0, 1, 0, 0, 0, 0, "R2");
    drive(4'd9, 4'd9, 0, 0, 1, 1, 0, 0, 0, 0, "R2");
    drive(4'd2, 4'd5, 0, 1, 1, 0, 1, 0, 0, 0, "R2");
    drive(4'd6, 4'd1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    drive(4'd8, 4'd0, 1, 1, 0, 0, 1, 1, 0, 0, "R2");
    // R3: corrupted result digit, then R8 and R9 hold on idle
    drive(4'd1, 4'd2, 0, 0, 0, 0, 0, 1, 0, 1, "R3");
    idle(0, "R9");
    idle(0, "R8");
    idle(1, "R8");
    // R4: bad B parity bit
    drive(4'd7, 4'd6, 0, 0, 0, 1, 0, 1, 0, 2, "R4");
    // R5 with R8: A complement fault in the same cycle as a clear
    drive(4'd4, 4'd3, 1, 0, 0, 0, 0, 1, 1, 3, "R5");
    idle(1, "R8");
    // R6: wrong carry out
    drive(4'd8, 4'd8, 0, 0, 0, 1, 0, 1, 0, 4, "R6");
    idle(1, "R8");
    // R7: first digit with any carry in is fine, next digit with wrong carry in flags
    drive(4'd2, 4'd2, 0, 0, 1, 0, 0, 1, 0, 0, "R7");
    drive(4'd3, 4'd3, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
    idle(0, "R9");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule